// File: doc/BRIEF.md
# Serial Quad DAC Register Interface

This block is the digital front end of a four-channel 14-bit digital-to-analog converter. A host loads it over a three-wire serial bus made of a data line, a serial clock and an active-low frame-sync line. Serial frames become 14-bit codes, and each code lands in one of four channel input registers. Every channel is double-buffered: its input register feeds an output latch, and the latch value is what drives the converter.

Many such devices can sit on one shared bus. Each device gets a five-bit identity from strap inputs tied high or low. A control frame names a target identity and a channel. Data frames that follow are taken only by the device whose straps match. A load strobe decides when the latches follow their input registers. While it is high the latches hold. While it is low they are transparent, so a pulse updates all four channels together, and holding it low lets each channel update as soon as its data arrives. An asynchronous clear forces every latch to a clear code without needing the clock. The serial lines are sampled by the system clock through a short synchronizer.

Top module: `sqdac_top`

## Requirements
- R1: After `rst_n` is released, all four outputs and all four input registers hold the clear code `CLR_CODE` (default 14'h2000).
- R2: A frame is 16 bits. They are sampled MSB first on rising edges of `sclk` while `fsync_n` is low. A data frame has bits 15:14 = 00 and carries the code in bits 13:0.
- R3: A control frame has bit 15 = 1. Bits 14:10 hold a target address and bits 9:8 a channel number (0 selects bits 13:0 of `dac_codes`, channel n selects bits 14n+13:14n). The selection persists over any number of later data frames until the next control frame.
- R4: A data frame changes nothing unless the address in the most recent control frame equals `strap_addr`.
- R5: If `fsync_n` rises before the 16th bit, the frame is discarded and nothing is written.
- R6: While `ldac_n` is high, the outputs hold their values even when input registers are written. When `ldac_n` goes low, all four outputs take their input register values.
- R7: While `ldac_n` is low, an accepted data frame reaches its channel's output directly.
- R8: Driving `clr_n` low sets all four outputs to `CLR_CODE` at once, without a clock edge. The input registers keep their contents, and a later low on `ldac_n` restores them to the outputs.
- R9: An accepted data frame changes only the selected channel.
- R10: Frames with bits 15:14 = 01 are ignored. Bits clocked in after the 16th, before `fsync_n` rises, are also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| strap_addr | input | 5 | Device identity straps |
| sclk | input | 1 | Serial clock, data taken on its rising edge |
| fsync_n | input | 1 | Active-low frame delimiter |
| sdin | input | 1 | Serial data, MSB first |
| ldac_n | input | 1 | Active-low load strobe, latches transparent while low |
| clr_n | input | 1 | Active-low asynchronous clear of the output latches |
| dac_codes | output | 56 | Four 14-bit latch values, channel 0 in the low bits |

## Verification
The bench sweeps every one of the 32 control addresses, each aimed at a different channel with its own code. A decoder that compared too few address bits would let foreign frames through, and one with a wrong channel field would corrupt a neighbouring channel. Short frames cut off by an early frame-sync and frames with extra trailing bits are sent to catch a bit counter that commits early or shifts past the 16th bit. The clear is applied with no clock edge in between, then released and followed by a strobe, so a synchronous clear or one that also wiped the input registers would show up. Walking-one and all-ones codes expose a reversed shift direction.

// File: rtl/sqdac_pkg.sv
package sqdac_pkg;
  localparam int FRAME_W = 16;
  localparam int CODE_W  = 14;
  localparam int ADDR_W  = 5;
  localparam int SEL_W   = 2;
  localparam int NCH     = 1 << SEL_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {FR_DATA, FR_CTRL, FR_RSVD} frame_kind_e;

  function automatic frame_kind_e classify(input logic [FRAME_W-1:0] w);
    if (w[FRAME_W-1])      return FR_CTRL;
    else if (w[FRAME_W-2]) return FR_RSVD;
    else                   return FR_DATA;
  endfunction

  function automatic logic [ADDR_W-1:0] ctrl_addr(input logic [FRAME_W-1:0] w);
    return w[FRAME_W-2 -: ADDR_W];
  endfunction

  function automatic logic [SEL_W-1:0] ctrl_sel(input logic [FRAME_W-1:0] w);
    return w[FRAME_W-2-ADDR_W -: SEL_W];
  endfunction

  function automatic logic [CODE_W-1:0] data_code(input logic [FRAME_W-1:0] w);
    return w[CODE_W-1:0];
  endfunction
endpackage

// File: rtl/sqdac_shifter.sv
module sqdac_shifter
  import sqdac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               fsync_n,
  input  logic               sdin,
  output logic               frame_done,
  output logic [FRAME_W-1:0] frame_word
);
  logic [SYNC_STAGES-1:0] sclk_p, fs_p, din_p;
  logic                   sclk_last;
  logic [CNT_W-1:0]       bit_cnt;
  logic [FRAME_W-2:0]     shreg;
  logic                   sclk_s, fs_s, din_s, sclk_rise, take_bit;

  assign sclk_s    = sclk_p[SYNC_STAGES-1];
  assign fs_s      = fs_p[SYNC_STAGES-1];
  assign din_s     = din_p[SYNC_STAGES-1];
  assign sclk_rise = sclk_s & ~sclk_last;
  assign take_bit  = sclk_rise & ~fs_s & (bit_cnt < CNT_W'(FRAME_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p    <= '0;
      fs_p      <= '1;
      din_p     <= '0;
      sclk_last <= 1'b0;
    end else begin
      sclk_p    <= {sclk_p[SYNC_STAGES-2:0], sclk};
      fs_p      <= {fs_p[SYNC_STAGES-2:0], fsync_n};
      din_p     <= {din_p[SYNC_STAGES-2:0], sdin};
      sclk_last <= sclk_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (fs_s) begin
      bit_cnt <= '0;
    end else if (take_bit) begin
      bit_cnt <= bit_cnt + 1'b1;
      shreg   <= {shreg[FRAME_W-3:0], din_s};
    end
  end

  assign frame_done = take_bit & (bit_cnt == CNT_W'(FRAME_W - 1));
  assign frame_word = {shreg, din_s};
endmodule

// File: rtl/sqdac_decode.sv
module sqdac_decode
  import sqdac_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  strap_addr,
  input  logic               frame_done,
  input  logic [FRAME_W-1:0] frame_word,
  output logic               addr_ok,
  output logic [NCH-1:0]     wr_en,
  output logic [CODE_W-1:0]  wr_code
);
  logic [SEL_W-1:0] sel;
  frame_kind_e      kind;

  assign kind    = classify(frame_word);
  assign wr_code = data_code(frame_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_ok <= 1'b0;
      sel     <= '0;
    end else if (frame_done && kind == FR_CTRL) begin
      addr_ok <= (ctrl_addr(frame_word) == strap_addr);
      sel     <= ctrl_sel(frame_word);
    end
  end

  always_comb begin
    for (int i = 0; i < NCH; i++)
      wr_en[i] = frame_done && (kind == FR_DATA) && addr_ok && (sel == SEL_W'(i));
  end
endmodule

// File: rtl/sqdac_bank.sv
module sqdac_bank
  import sqdac_pkg::*;
#(
  parameter logic [CODE_W-1:0] CLR_CODE = 14'h2000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_n,
  input  logic                  ldac_n,
  input  logic [NCH-1:0]        wr_en,
  input  logic [CODE_W-1:0]     wr_code,
  output logic [NCH*CODE_W-1:0] in_codes,
  output logic [NCH*CODE_W-1:0] dac_codes
);
  logic lat_rst_n;
  assign lat_rst_n = rst_n & clr_n;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [CODE_W-1:0] in_q, in_nxt, lat_q;
    assign in_nxt = wr_en[ch] ? wr_code : in_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) in_q <= CLR_CODE;
      else        in_q <= in_nxt;
    end

    always_ff @(posedge clk or negedge lat_rst_n) begin
      if (!lat_rst_n)  lat_q <= CLR_CODE;
      else if (!ldac_n) lat_q <= in_nxt;
    end

    assign in_codes[ch*CODE_W +: CODE_W]  = in_q;
    assign dac_codes[ch*CODE_W +: CODE_W] = lat_q;
  end
endmodule

// File: rtl/sqdac_top.sv
module sqdac_top
  import sqdac_pkg::*;
#(
  parameter logic [CODE_W-1:0] CLR_CODE    = 14'h2000,
  parameter int                SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     strap_addr,
  input  logic                  sclk,
  input  logic                  fsync_n,
  input  logic                  sdin,
  input  logic                  ldac_n,
  input  logic                  clr_n,
  output logic [NCH*CODE_W-1:0] dac_codes
);
  logic               frame_done;
  logic [FRAME_W-1:0] frame_word;
  logic               addr_ok;
  logic [NCH-1:0]     wr_en;
  logic [CODE_W-1:0]  wr_code;
  logic [NCH*CODE_W-1:0] in_codes;

  sqdac_shifter #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .fsync_n(fsync_n), .sdin(sdin),
    .frame_done(frame_done), .frame_word(frame_word));

  sqdac_decode u_dec (
    .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr),
    .frame_done(frame_done), .frame_word(frame_word),
    .addr_ok(addr_ok), .wr_en(wr_en), .wr_code(wr_code));

  sqdac_bank #(.CLR_CODE(CLR_CODE)) u_bank (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ldac_n(ldac_n),
    .wr_en(wr_en), .wr_code(wr_code),
    .in_codes(in_codes), .dac_codes(dac_codes));
endmodule

// File: rtl/sqdac_checker.sv
module sqdac_checker
  import sqdac_pkg::*;
#(
  parameter logic [CODE_W-1:0] CLR_CODE = 14'h2000
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  clr_n,
  input logic                  ldac_n,
  input logic                  addr_ok,
  input logic [NCH-1:0]        wr_en,
  input logic [NCH*CODE_W-1:0] in_codes,
  input logic [NCH*CODE_W-1:0] dac_codes
);
  p_clear_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> dac_codes == {NCH{CLR_CODE}});

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ldac_n && clr_n) |=> (!clr_n || $stable(dac_codes)));

  p_transparent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ldac_n && clr_n) |=> (!clr_n || dac_codes == in_codes));

  p_single_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));

  p_match_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_en) |-> addr_ok);
endmodule

bind sqdac_top sqdac_checker #(.CLR_CODE(CLR_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ldac_n(ldac_n),
  .addr_ok(addr_ok), .wr_en(wr_en), .in_codes(in_codes), .dac_codes(dac_codes));

// File: tb/sqdac_top_test.sv
module sqdac_top_test;
  localparam logic [13:0] CLR   = 14'h2000;
  localparam logic [4:0]  STRAP = 5'b10110;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  strap_addr = STRAP;
  logic        sclk = 1'b0, fsync_n = 1'b1, sdin = 1'b0, ldac_n = 1'b1, clr_n = 1'b1;
  logic [55:0] dac_codes;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [13:0] m_in [4];
  logic [13:0] m_dac [4];
  bit m_ok = 1'b0;
  int m_ch = 0;

  always #4 clk = ~clk;

  sqdac_top uut (.clk(clk), .rst_n(rst_n), .strap_addr(strap_addr), .sclk(sclk),
    .fsync_n(fsync_n), .sdin(sdin), .ldac_n(ldac_n), .clr_n(clr_n), .dac_codes(dac_codes));

  function automatic logic [13:0] code_of(input int a);
    return 14'((a * 517 + 3) & 16'h3FFF);
  endfunction

  task automatic check(input string req);
    logic [55:0] exp;
    for (int i = 0; i < 4; i++) exp[i*14 +: 14] = m_dac[i];
    checks++;
    if (dac_codes !== exp) begin
      fails++;
      $display("FAIL %s: dac_codes=%h expected=%h", req, dac_codes, exp);
    end
  endtask

  task automatic send_bits(input logic [31:0] w, input int n);
    @(negedge clk); fsync_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int b = n - 1; b >= 0; b--) begin
      sdin = w[b];
      repeat (3) @(negedge clk); sclk = 1'b1;
      repeat (3) @(negedge clk); sclk = 1'b0;
    end
    repeat (3) @(negedge clk); fsync_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic ctrl(input int a, input int ch);
    send_bits({16'h0, 1'b1, 5'(a), 2'(ch), 8'h00}, 16);
    m_ok = (5'(a) == STRAP);
    m_ch = ch;
  endtask

  task automatic data(input logic [13:0] c);
    send_bits({16'h0, 2'b00, c}, 16);
    if (m_ok) begin
      m_in[m_ch] = c;
      if (!ldac_n) m_dac[m_ch] = c;
    end
  endtask

  task automatic pulse_ldac;
    @(negedge clk); ldac_n = 1'b0;
    repeat (2) @(negedge clk); ldac_n = 1'b1;
    for (int i = 0; i < 4; i++) m_dac[i] = m_in[i];
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin m_in[i] = CLR; m_dac[i] = CLR; end
    repeat (3) @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 reset level");

    ctrl(22, 2); data(14'h1234);
    check("R6 hold while strobe high");
    pulse_ldac;
    check("R6 strobe transfer");
    check("R2 code placement");

    ldac_n = 1'b0; @(negedge clk);
    for (int a = 0; a < 32; a++) begin
      ctrl(a, a % 4); data(code_of(a));
      check(a == 22 ? "R7 transparent write" : "R4 foreign address ignored");
    end
    data(14'h0ABC);
    check("R4 stale mismatch ignored");

    ctrl(22, 0); data(14'h0111);
    check("R3 select ch0");
    data(14'h3EEE);
    check("R3 persistence");
    check("R9 other channels untouched");

    ctrl(22, 1);
    send_bits({16'h0, 2'b00, 14'h1555}, 10);
    check("R5 aborted frame");
    data(14'h0F0F);
    check("R5 full frame after abort");

    send_bits({16'h0, 2'b01, 14'h2AAA}, 16);
    check("R10 reserved frame ignored");
    send_bits({12'h0, 2'b00, 14'h0777, 4'hF}, 20);
    m_in[1] = 14'h0777; m_dac[1] = 14'h0777;
    check("R10 trailing bits ignored");

    ctrl(22, 3);
    data(14'h0001); check("R2 lsb only");
    data(14'h2000); check("R2 msb only");
    data(14'h3FFF); check("R2 all ones");
    data(14'h0000); check("R2 all zeros");

    ldac_n = 1'b1; @(negedge clk);
    data(14'h2468);
    check("R6 buffered write held");
    @(negedge clk); clr_n = 1'b0; #1;
    for (int i = 0; i < 4; i++) m_dac[i] = CLR;
    check("R8 asynchronous clear");
    repeat (4) @(negedge clk); clr_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 clear held after release");
    pulse_ldac;
    check("R8 input registers retained");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule